// File: doc/BRIEF.md
# DRAM Row/Column Address Multiplexer

This controller connects a host port carrying a full-width address to a dynamic memory whose address pins are only half as wide. Each host read or write becomes a fixed strobe sequence. The lower half of the address goes out first and is captured by the row strobe. The upper half follows and is captured by the column strobe. The write enable and output enable are driven around these two strobes. Between host accesses, the controller inserts row-only refresh cycles from its own interval timer. These cycles walk a row counter through every row, so that each row is rewritten well inside the retention window.

The host raises a request together with its address, direction and write data. It holds these until the ready signal is seen high at a clock edge. A read returns its data with a one-cycle response pulse. A due refresh always starts before a waiting host request, and the host is stalled meanwhile. The default interval of 976 cycles covers 256 rows in under 2 ms at 125 MHz.

Top module: `dramRowColMux`

## Requirements
- R1: During and right after reset, the row strobe, column strobe, write enable and output enable are all high (inactive), the response pulse is low, and the controller is ready.
- R2: A host access puts address bits [ADDR_W/2-1:0] (the row half) on the pin bus for one cycle with the row strobe high. The row strobe then falls while the same value stays on the bus, two cycles after the accepting edge.
- R3: After the row strobe falls, address bits [ADDR_W-1:ADDR_W/2] (the column half) go on the pin bus. The column strobe falls four cycles after the accepting edge, and only while the row strobe is low.
- R4: On a write, the write enable is already low in the cycle before the column strobe falls. The memory stores the write data at the address formed as {column half, row half}.
- R5: The output enable is low only in the data phase of a read, with the column strobe low and the write enable high. The read data appears on the response bus with a one-cycle response pulse, six cycles after the accepting edge.
- R6: Every row strobe fall is preceded by at least two cycles of the row strobe high: one precharge cycle with both strobes inactive, and one row setup cycle. The column strobe is also high at that moment.
- R7: Every REF_INTERVAL cycles a refresh falls due. It puts the refresh row counter on the pin bus and pulses the row strobe while the column strobe stays high. The counter steps through the rows in ascending order and wraps. Consecutive refreshes are spaced REF_INTERVAL cycles apart, to within one access length.
- R8: While a refresh is due or running, ready is low and no host access starts; a waiting host request is served after the refresh completes.
- R9: Every row sees a row strobe, from a refresh or a host access, within ROWS*REF_INTERVAL plus a small slack of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Host request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Host address; low half is the row, high half the column |
| reqWdata | input | DATA_W | Write data |
| reqReady | output | 1 | Request accepted at this edge when high with reqValid |
| rspValid | output | 1 | One-cycle read data pulse |
| rspRdata | output | DATA_W | Read data |
| memAddr | output | ADDR_W/2 | Multiplexed address pins |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memDout | output | DATA_W | Data to the memory |
| memDin | input | DATA_W | Data from the memory |

## Verification
The bench uses an 8-bit address and a 40-cycle refresh interval, so the memory has 16 rows and 256 locations. It writes every location with a pattern that mixes the row and column halves, reads all of them back, then repeats this with the inverted pattern in descending order. A swapped or truncated address half therefore lands data in the wrong place, and the column-strobe address check catches it. The continuous stream of requests makes refreshes collide with host requests at every phase. This shows whether a refresh really takes precedence and stalls the host, keeps its rows in order, and keeps every row inside the retention limit.

// File: rtl/dramRowColPkg.sv
package dramRowColPkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ROW_SETUP,
    S_ROW_STROBE,
    S_COL_SETUP,
    S_COL_STROBE,
    S_DATA,
    S_PRECHARGE
  } phase_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic latchReq;  // capture host address, data and direction
    logic selCol;    // drive column half on the pins
    logic selRef;    // drive refresh row on the pins
    logic capture;   // take read data from the memory
    logic refStep;   // advance the refresh row counter
  } pathCtl_t;

endpackage

// File: rtl/dramRowColCtrl.sv
module dramRowColCtrl
  import dramRowColPkg::*;
#(
  parameter int REF_INTERVAL = 976
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     latWrite,
  output logic     reqReady,
  output pathCtl_t ctl,
  output logic     rasN,
  output logic     casN,
  output logic     weN,
  output logic     oeN
);

  localparam int TW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;

  phase_t        state;
  phase_t        nextState;
  logic          isRef;
  logic          refPending;
  logic [TW-1:0] refTimer;
  logic          timerWrap;
  logic          startRef;
  logic          startHost;

  assign timerWrap = (refTimer == TW'(REF_INTERVAL - 1));
  assign startRef  = (state == S_IDLE) && refPending;
  assign startHost = (state == S_IDLE) && !refPending && reqValid;
  assign reqReady  = (state == S_IDLE) && !refPending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refTimer   <= '0;
      refPending <= 1'b0;
    end else begin
      refTimer <= timerWrap ? '0 : refTimer + 1'b1;
      if (startRef)  refPending <= 1'b0;
      if (timerWrap) refPending <= 1'b1;
    end
  end

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:       if (startRef || startHost) nextState = S_ROW_SETUP;
      S_ROW_SETUP:  nextState = S_ROW_STROBE;
      S_ROW_STROBE: nextState = isRef ? S_PRECHARGE : S_COL_SETUP;
      S_COL_SETUP:  nextState = S_COL_STROBE;
      S_COL_STROBE: nextState = S_DATA;
      S_DATA:       nextState = S_PRECHARGE;
      S_PRECHARGE:  nextState = S_IDLE;
      default:      nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      isRef <= 1'b0;
    end else begin
      state <= nextState;
      if (startRef)       isRef <= 1'b1;
      else if (startHost) isRef <= 1'b0;
    end
  end

  logic inColPhase;
  assign inColPhase = state inside {S_COL_SETUP, S_COL_STROBE, S_DATA};

  assign rasN = !(state inside {S_ROW_STROBE, S_COL_SETUP, S_COL_STROBE, S_DATA});
  assign casN = !(state inside {S_COL_STROBE, S_DATA});
  assign weN  = !(latWrite && !isRef && inColPhase);
  assign oeN  = !(!latWrite && !isRef && state == S_DATA);

  always_comb begin
    ctl          = '0;
    ctl.latchReq = startHost;
    ctl.selCol   = inColPhase;
    ctl.selRef   = isRef;
    ctl.capture  = (state == S_DATA) && !latWrite && !isRef;
    ctl.refStep  = isRef && (state == S_ROW_STROBE);
  end

  // R3: column strobe only inside an open row
  p_cas_inside_ras_r3: assert property (@(posedge clk) disable iff (!rstN)
    !casN |-> !rasN);
  // R4: write enable settles before the column strobe falls
  p_we_early_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(casN) && !weN) |-> !$past(weN));
  // R5: output enable only in a read data phase
  p_oe_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> (!casN && weN));
  // R6: precharge plus row setup before each row strobe
  p_precharge_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> ($past(rasN, 1) && $past(rasN, 2) && casN));
  // R7: a refresh never opens a column
  p_ref_no_cas_r7: assert property (@(posedge clk) disable iff (!rstN)
    (isRef && state != S_IDLE) |-> casN);
  // R8: a host request seen while not ready does not start an access
  p_host_blocked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> !(state == S_ROW_SETUP && !isRef));

endmodule

// File: rtl/dramRowColPath.sv
module dramRowColPath
  import dramRowColPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtl_t          ctl,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic              latWrite,
  output logic [ADDR_W/2-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata
);

  localparam int ROW_W = ADDR_W / 2;

  logic [ADDR_W-1:0] latAddr;
  logic [DATA_W-1:0] latData;
  logic [ROW_W-1:0]  refRow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latAddr  <= '0;
      latData  <= '0;
      latWrite <= 1'b0;
      refRow   <= '0;
      rspValid <= 1'b0;
      rspRdata <= '0;
    end else begin
      if (ctl.latchReq) begin
        latAddr  <= reqAddr;
        latData  <= reqWdata;
        latWrite <= reqWrite;
      end
      if (ctl.refStep) refRow <= refRow + 1'b1;
      rspValid <= ctl.capture;
      if (ctl.capture) rspRdata <= memDin;
    end
  end

  always_comb begin
    if (ctl.selRef)      memAddr = refRow;
    else if (ctl.selCol) memAddr = latAddr[ADDR_W-1:ROW_W];
    else                 memAddr = latAddr[ROW_W-1:0];
  end

  assign memDout = latData;

  // R5: read data pulse lasts a single cycle
  p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: rtl/dramRowColMux.sv
module dramRowColMux
  import dramRowColPkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 4,
  parameter int REF_INTERVAL = 976
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                reqReady,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspRdata,
  output logic [ADDR_W/2-1:0] memAddr,
  output logic                memRasN,
  output logic                memCasN,
  output logic                memWeN,
  output logic                memOeN,
  output logic [DATA_W-1:0]   memDout,
  input  logic [DATA_W-1:0]   memDin
);

  localparam int ROW_W = ADDR_W / 2;

  pathCtl_t ctl;
  logic     latWrite;

  dramRowColCtrl #(.REF_INTERVAL(REF_INTERVAL)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .latWrite(latWrite),
    .reqReady(reqReady), .ctl(ctl),
    .rasN(memRasN), .casN(memCasN), .weN(memWeN), .oeN(memOeN)
  );

  dramRowColPath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .memDin(memDin),
    .latWrite(latWrite), .memAddr(memAddr), .memDout(memDout),
    .rspValid(rspValid), .rspRdata(rspRdata)
  );

  // R2: row half latched by the row strobe two cycles after acceptance
  p_row_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> ##1
      (!memRasN && memCasN && memAddr == $past(reqAddr[ROW_W-1:0], 2)));
  // R3: column half latched by the column strobe four cycles after acceptance
  p_col_second_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> ##3
      (!memCasN && memAddr == $past(reqAddr[ADDR_W-1:ROW_W], 4)));

endmodule

// File: tb/dramRowColMux_test.sv
module dramRowColMux_test;

  localparam int AW    = 8;
  localparam int DW    = 4;
  localparam int PW    = AW / 2;
  localparam int RI    = 40;
  localparam int ROWS  = 1 << PW;
  localparam int LIMIT = ROWS * RI + 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          reqReady;
  logic          rspValid;
  logic [DW-1:0] rspRdata;
  logic [PW-1:0] memAddr;
  logic          memRasN, memCasN, memWeN, memOeN;
  logic [DW-1:0] memDout;
  logic [DW-1:0] memDin = '0;

  dramRowColMux #(.ADDR_W(AW), .DATA_W(DW), .REF_INTERVAL(RI)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspValid(rspValid), .rspRdata(rspRdata), .memAddr(memAddr),
    .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN), .memOeN(memOeN),
    .memDout(memDout), .memDin(memDin)
  );

  always #4 clk = ~clk;  // 8-unit period, 125 MHz

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Behavioural memory and bus monitor
  logic [DW-1:0] mem [ROWS*ROWS];
  logic [DW-1:0] shadow [ROWS*ROWS];
  int            lastRas [ROWS];
  logic [PW-1:0] rowLat = '0, colLat = '0, prevAddr = '0, expRefRow = '0;
  logic          prevRas = 1'b1, prevCas = 1'b1, prevWe = 1'b1;
  int            rasRun = 0;
  int            lastRefCyc = -1;
  bit            hostActive = 1'b0;
  logic [AW-1:0] curAddr = '0;
  bit            curWrite = 1'b0;

  always @(negedge clk) if (rstN) begin
    if (prevRas && !memRasN) begin
      rowLat = memAddr;
      chk(rasRun >= 2 && memCasN, "R6", rasRun, 2);
      if (hostActive) begin
        chk(memAddr == curAddr[PW-1:0] && prevAddr == memAddr, "R2",
            int'(memAddr), int'(curAddr[PW-1:0]));
      end else begin
        chk(memAddr == expRefRow, "R7", int'(memAddr), int'(expRefRow));
        chk(!reqReady, "R8", int'(reqReady), 0);
        if (lastRefCyc >= 0)
          chk((cyc - lastRefCyc) >= RI - 7 && (cyc - lastRefCyc) <= RI + 7, "R7",
              cyc - lastRefCyc, RI);
        lastRefCyc = cyc;
        expRefRow  = expRefRow + 1'b1;
      end
      lastRas[memAddr] = cyc;
    end
    if (prevCas && !memCasN) begin
      colLat = memAddr;
      chk(hostActive && !memRasN && memAddr == curAddr[AW-1:PW], "R3",
          int'(memAddr), int'(curAddr[AW-1:PW]));
      if (!memWeN) begin
        chk(curWrite && !prevWe, "R4", int'(prevWe), 0);
        mem[{colLat, rowLat}] = memDout;
      end
    end
    if (!memOeN)
      chk(!memCasN && memWeN && hostActive && !curWrite, "R5", int'(memCasN), 0);
    if (!hostActive && !memCasN)
      chk(1'b0, "R7", int'(memCasN), 1);
    if (!memCasN) memDin = mem[{colLat, rowLat}];
    rasRun   = memRasN ? rasRun + 1 : 0;
    prevRas  = memRasN;
    prevCas  = memCasN;
    prevWe   = memWeN;
    prevAddr = memAddr;
  end

  // Retention coverage sampled periodically
  always @(negedge clk) if (rstN && cyc > 0 && (cyc % 200) == 0) begin
    for (int r = 0; r < ROWS; r++)
      chk((cyc - lastRas[r]) <= LIMIT, "R9", cyc - lastRas[r], LIMIT);
  end

  task automatic doOp(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    curAddr = a; curWrite = wr;
    @(posedge clk);
    #1 reqValid = 1'b0;
    hostActive = 1'b1;
    repeat (6) @(negedge clk);
    if (wr) begin
      shadow[a] = d;
      chk(!rspValid, "R5", int'(rspValid), 0);
    end else begin
      chk(rspValid && rspRdata == shadow[a], "R5",
          int'({rspValid, rspRdata}), int'({1'b1, shadow[a]}));
    end
    hostActive = 1'b0;
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a) ^ DW'(a >> PW) ^ DW'(5);
  endfunction

  task automatic finishRun;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < ROWS*ROWS; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    chk(memRasN && memCasN && memWeN && memOeN && !rspValid, "R1",
        int'({memRasN, memCasN, memWeN, memOeN, rspValid}), 5'b11110);
    rstN = 1'b1;
    for (int r = 0; r < ROWS; r++) lastRas[r] = cyc;
    @(negedge clk);
    chk(reqReady && memRasN && memCasN && memWeN && memOeN && !rspValid, "R1",
        int'({reqReady, memRasN, memCasN, memWeN, memOeN, rspValid}), 6'b111110);
    for (int a = 0; a < ROWS*ROWS; a++) doOp(1'b1, AW'(a), pat(a));
    for (int a = 0; a < ROWS*ROWS; a++) doOp(1'b0, AW'(a), '0);
    for (int a = ROWS*ROWS-1; a >= 0; a--) doOp(1'b1, AW'(a), ~pat(a));
    for (int a = ROWS*ROWS-1; a >= 0; a--) doOp(1'b0, AW'(a), '0);
    // idle stretch: refresh alone must keep every row alive (R9)
    repeat (LIMIT + 200) @(negedge clk);
    for (int r = 0; r < ROWS; r++)
      chk((cyc - lastRas[r]) <= LIMIT, "R9", cyc - lastRas[r], LIMIT);
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    finishRun();
  end

endmodule